// File: doc/BRIEF.md
# Prefetching ROM Read Port

This block lets a host CPU stream bytes out of a large data ROM through a small register window. The host sets a 24-bit byte offset and a bank number, then triggers a fetch. The port loads a one-byte read buffer from the ROM. From then on, each read of the data register returns the buffered byte and starts a background fetch of the following byte. A software loop therefore reads consecutive ROM bytes at one register address without reprogramming anything.

The ROM sits behind a request/acknowledge handshake with any latency. The port holds the request and the address steady until the acknowledge arrives. A busy flag that the host can read shows when a fetch is still outstanding. After power-on the data register reads as zero until the host has written a trigger register for the first time.

Register map (3-bit register address, 8-bit data):

| Address | Read | Write |
|---|---|---|
| 0 | buffered byte (consumes it) | ignored |
| 1, 2 | offset bits 7:0, 15:8 | set those offset bits |
| 3 | offset bits 23:16 | set those bits and trigger a fetch |
| 4 | bit 0 = busy | trigger a fetch |
| 5 | bank select, bits 2:0 | set bank |
| 6, 7 | auxiliary bank values, bits 2:0 | store only |

Top module: `rom_read_port`

## Requirements
- R1: After reset every register address reads 0x00, romReq is low and the busy bit (address 4, bit 0) is 0.
- R2: Until the first write to address 3 or address 4, a read of address 0 returns 0x00 and raises no ROM request.
- R3: A write to address 3 or address 4 raises romReq on the following clock edge. The request uses the offset as it stands after that write. When romAck arrives, romData is loaded into the read buffer.
- R4: Once primed, a read of address 0 returns the buffered byte in the same cycle. The next clock edge raises a request for the next ROM byte, with no other register write needed.
- R5: romAddr is {bank, offset}. Its top 3 bits come only from the bank register at address 5. The registers at addresses 6 and 7 can be read back but never affect romAddr.
- R6: Every completed fetch increments the 24-bit offset (address 1 is the low byte, address 3 the high byte) by one, modulo 2^24.
- R7: romReq and romAddr stay stable from the request until romAck, and the busy bit is 1 over that span. A data read or a trigger write during that span returns the previous buffer, starts no new fetch, and leaves the offset advancing only once.
- R8: Register bits that are not implemented read as zero. At address 4 that is bits 7:1, and at addresses 5 to 7 it is bits 7:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register address |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid in the cycle of regRd |
| romReq | output | 1 | ROM fetch request, held until acknowledged |
| romAddr | output | 27 | ROM byte address {bank, offset} |
| romAck | input | 1 | One-cycle acknowledge with data |
| romData | input | 8 | ROM byte, valid with romAck |

## Verification
Read data is combinational, so the bench samples it one time unit after it drives regRd, inside the same cycle. A trigger write or a consuming read is captured at one rising edge. romReq and romAddr must then be visible at the following falling edge, and the bench checks them there. The buffer and the offset change on the edge that captures romAck. The bench therefore polls romReq low before it reads the data or the offset back. It checks read-while-busy behaviour one cycle after a request rises, while the ROM model still withholds the acknowledge.

// File: rtl/rrp_pkg.sv
package rrp_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] REG_DATA = 3'd0;
  localparam logic [REG_AW-1:0] REG_OFS0 = 3'd1;
  localparam logic [REG_AW-1:0] REG_TRIG = 3'd4;
  localparam logic [REG_AW-1:0] REG_BANK = 3'd5;
  localparam logic [REG_AW-1:0] REG_AUX0 = 3'd6;

  typedef enum logic {
    FETCH_IDLE,
    FETCH_WAIT
  } fetchState_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic startFetch;  // latch {bank, offset} as the ROM address
    logic loadBuf;     // capture romData, advance the offset
  } rrpStrobe_t;
endpackage

// File: rtl/rrp_ctrl.sv
module rrp_ctrl
  import rrp_pkg::*;
#(
  parameter int OFS_BYTES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic              romAck,
  output rrpStrobe_t        strobes,
  output logic              primed,
  output logic              busy
);
  localparam logic [REG_AW-1:0] TRIG_HI = REG_OFS0 + REG_AW'(OFS_BYTES - 1);

  fetchState_t stateQ, stateD;
  logic primedQ;
  logic trigWr, dataRd;

  assign trigWr = regWr && (regAddr == TRIG_HI || regAddr == REG_TRIG);
  assign dataRd = regRd && (regAddr == REG_DATA);

  always_comb begin
    stateD             = stateQ;
    strobes.startFetch = 1'b0;
    strobes.loadBuf    = 1'b0;
    case (stateQ)
      FETCH_IDLE: begin
        // a read consumes only once primed; triggers always start
        if (trigWr || (dataRd && primedQ)) begin
          strobes.startFetch = 1'b1;
          stateD             = FETCH_WAIT;
        end
      end
      FETCH_WAIT: begin
        // requests arriving here are dropped, pending fetch kept
        if (romAck) begin
          strobes.loadBuf = 1'b1;
          stateD          = FETCH_IDLE;
        end
      end
      default: stateD = FETCH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= FETCH_IDLE;
      primedQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (trigWr) primedQ <= 1'b1;
    end
  end

  assign primed = primedQ;
  assign busy   = (stateQ == FETCH_WAIT);
endmodule

// File: rtl/rrp_datapath.sv
module rrp_datapath
  import rrp_pkg::*;
#(
  parameter int OFS_W   = 24,
  parameter int BANK_W  = 3,
  parameter int DATA_W  = 8,
  parameter int NUM_AUX = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [REG_AW-1:0]         regAddr,
  input  logic                      regWr,
  input  logic                      regRd,
  input  logic [DATA_W-1:0]         wrData,
  input  rrpStrobe_t                strobes,
  input  logic                      primed,
  input  logic                      busy,
  input  logic [DATA_W-1:0]         romData,
  output logic [OFS_W+BANK_W-1:0]   romAddr,
  output logic [DATA_W-1:0]         rdData
);
  localparam int OFS_BYTES = OFS_W / DATA_W;
  localparam int ROM_AW    = OFS_W + BANK_W;

  logic [OFS_W-1:0]     offsetQ, offsetWr;
  logic [OFS_BYTES-1:0] ofsSel;
  logic [BANK_W-1:0]    bankQ;
  logic [BANK_W-1:0]    auxQ [NUM_AUX];
  logic [DATA_W-1:0]    bufQ;
  logic [ROM_AW-1:0]    romAddrQ;

  // per-byte write merge of the offset register
  for (genvar i = 0; i < OFS_BYTES; i++) begin : g_ofs
    assign ofsSel[i] = regWr && (regAddr == REG_OFS0 + REG_AW'(i));
    assign offsetWr[i*DATA_W +: DATA_W] =
      ofsSel[i] ? wrData : offsetQ[i*DATA_W +: DATA_W];
  end

  // a host write to the offset takes priority over the post-fetch increment
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                offsetQ <= '0;
    else if (|ofsSel)         offsetQ <= offsetWr;
    else if (strobes.loadBuf) offsetQ <= offsetQ + OFS_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankQ    <= '0;
      bufQ     <= '0;
      romAddrQ <= '0;
    end else begin
      if (regWr && regAddr == REG_BANK) bankQ <= wrData[BANK_W-1:0];
      if (strobes.loadBuf)              bufQ  <= romData;
      // offsetWr carries a same-cycle high-byte write that triggers
      if (strobes.startFetch)           romAddrQ <= {bankQ, offsetWr};
    end
  end

  // stored-only neighbour bank values
  for (genvar i = 0; i < NUM_AUX; i++) begin : g_aux
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) auxQ[i] <= '0;
      else if (regWr && regAddr == REG_AUX0 + REG_AW'(i)) auxQ[i] <= wrData[BANK_W-1:0];
    end
  end

  always_comb begin
    rdData = '0;
    if (regRd) begin
      if (regAddr == REG_DATA) rdData = primed ? bufQ : '0;
      if (regAddr == REG_TRIG) rdData = DATA_W'(busy);
      if (regAddr == REG_BANK) rdData = DATA_W'(bankQ);
      for (int i = 0; i < OFS_BYTES; i++)
        if (regAddr == REG_OFS0 + REG_AW'(i)) rdData = offsetQ[i*DATA_W +: DATA_W];
      for (int i = 0; i < NUM_AUX; i++)
        if (regAddr == REG_AUX0 + REG_AW'(i)) rdData = DATA_W'(auxQ[i]);
    end
  end

  assign romAddr = romAddrQ;
endmodule

// File: rtl/rom_read_port.sv
module rom_read_port
  import rrp_pkg::*;
#(
  parameter int OFS_W   = 24,
  parameter int BANK_W  = 3,
  parameter int DATA_W  = 8,
  parameter int NUM_AUX = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [REG_AW-1:0]       regAddr,
  input  logic                    regWr,
  input  logic                    regRd,
  input  logic [DATA_W-1:0]       wrData,
  output logic [DATA_W-1:0]       rdData,
  output logic                    romReq,
  output logic [OFS_W+BANK_W-1:0] romAddr,
  input  logic                    romAck,
  input  logic [DATA_W-1:0]       romData
);
  localparam int OFS_BYTES = OFS_W / DATA_W;

  rrpStrobe_t strobes;
  logic primed, busy;

  rrp_ctrl #(.OFS_BYTES(OFS_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .romAck(romAck), .strobes(strobes), .primed(primed), .busy(busy)
  );

  rrp_datapath #(.OFS_W(OFS_W), .BANK_W(BANK_W), .DATA_W(DATA_W), .NUM_AUX(NUM_AUX)) u_dp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .wrData(wrData), .strobes(strobes), .primed(primed), .busy(busy),
    .romData(romData), .romAddr(romAddr), .rdData(rdData)
  );

  assign romReq = busy;
endmodule

// File: rtl/rrp_checker.sv
module rrp_checker
  import rrp_pkg::*;
#(
  parameter int OFS_W  = 24,
  parameter int BANK_W = 3,
  parameter int DATA_W = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [REG_AW-1:0]       regAddr,
  input logic                    regWr,
  input logic                    regRd,
  input logic [DATA_W-1:0]       wrData,
  input logic [DATA_W-1:0]       rdData,
  input logic                    romReq,
  input logic [OFS_W+BANK_W-1:0] romAddr,
  input logic                    romAck
);
  localparam int ROM_AW = OFS_W + BANK_W;
  localparam logic [REG_AW-1:0] TRIG_HI = REG_OFS0 + REG_AW'(OFS_W / DATA_W - 1);

  logic primedSeen;
  logic [DATA_W-1:0] bankShadow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primedSeen <= 1'b0;
      bankShadow <= '0;
    end else begin
      if (regWr && (regAddr == TRIG_HI || regAddr == REG_TRIG)) primedSeen <= 1'b1;
      if (regWr && regAddr == REG_BANK) bankShadow <= wrData;
    end
  end

  p_unprimed_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == REG_DATA && !primedSeen) |-> rdData == '0);

  p_unprimed_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !primedSeen |-> !romReq);

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (romReq && !romAck) |=> (romReq && $stable(romAddr)));

  p_ack_ends_r7: assert property (@(posedge clk) disable iff (!rstN)
    (romReq && romAck) |=> !romReq);

  p_bank_source_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(romReq) |-> romAddr[ROM_AW-1:OFS_W] == $past(bankShadow[BANK_W-1:0]));

  p_status_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == REG_TRIG) |-> rdData[DATA_W-1:1] == '0);

  p_bank_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr >= REG_BANK) |-> rdData[DATA_W-1:BANK_W] == '0);
endmodule

bind rom_read_port rrp_checker #(.OFS_W(OFS_W), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
  .wrData(wrData), .rdData(rdData), .romReq(romReq), .romAddr(romAddr), .romAck(romAck)
);

// File: tb/sim_rom_read_port.sv
`timescale 1ns/1ps
module sim_rom_read_port;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic romReq;
  logic [26:0] romAddr;
  logic romAck = 1'b0;
  logic [7:0] romData = '0;

  int runCount = 0, failCount = 0;
  bit done = 1'b0;
  int romCnt = 0;

  always #2.5 clk = ~clk;

  rom_read_port u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .wrData(wrData), .rdData(rdData), .romReq(romReq), .romAddr(romAddr),
    .romAck(romAck), .romData(romData)
  );

  function automatic logic [7:0] romByte(logic [26:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ {a[26:24], 5'd0};
  endfunction

  // ROM model: acknowledges LAT falling edges after the request is seen
  always @(negedge clk) begin
    if (!rstN) begin
      romAck <= 1'b0; romCnt <= 0;
    end else if (romAck) begin
      romAck <= 1'b0; romCnt <= 0;
    end else if (romReq) begin
      if (romCnt == LAT - 1) begin
        romAck  <= 1'b1;
        romData <= romByte(romAddr);
      end
      romCnt <= romCnt + 1;
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    runCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(logic [2:0] a, logic [7:0] d);
    @(negedge clk); regAddr = a; wrData = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
    #1;
  endtask

  task automatic hostRead(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; regRd = 1'b1;
    #1 d = rdData;
    @(negedge clk); regRd = 1'b0;
    #1;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 40 && romReq; i++) @(negedge clk);
    @(negedge clk); #1;
  endtask

  task automatic readOffset(output logic [23:0] o);
    logic [7:0] b0, b1, b2;
    hostRead(3'd1, b0); hostRead(3'd2, b1); hostRead(3'd3, b2);
    o = {b2, b1, b0};
  endtask

  initial begin
    logic [7:0] d, prev;
    logic [23:0] ofs;
    logic [26:0] addr;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      hostRead(3'(a), d);
      check(d == 8'h00, "R1 reset read", d, 0);
    end
    check(romReq == 1'b0, "R1 no request", romReq, 0);

    // R2: unprimed data reads
    for (int i = 0; i < 3; i++) begin
      hostRead(3'd0, d);
      check(d == 8'h00, "R2 unprimed data", d, 0);
      check(romReq == 1'b0, "R2 no fetch", romReq, 0);
    end

    // R8: masked bank registers
    hostWrite(3'd5, 8'hFF); hostRead(3'd5, d);
    check(d == 8'h07, "R8 bank mask", d, 8'h07);
    hostWrite(3'd6, 8'hAA); hostRead(3'd6, d);
    check(d == 8'h02, "R8 aux mask", d, 8'h02);
    hostWrite(3'd7, 8'h5D); hostRead(3'd7, d);
    check(d == 8'h05, "R8 aux mask", d, 8'h05);

    // R3/R5: trigger by writing the high offset byte
    hostWrite(3'd1, 8'h12); hostWrite(3'd2, 8'h34);
    check(romReq == 1'b0, "R3 low bytes do not trigger", romReq, 0);
    hostWrite(3'd3, 8'h56);
    addr = {3'd7, 24'h563412};
    check(romReq == 1'b1, "R3 request raised", romReq, 1);
    check(romAddr == addr, "R5 request address", romAddr, addr);
    hostRead(3'd4, d);
    check(d == 8'h01, "R7 busy bit", d, 1);
    waitIdle();
    hostRead(3'd4, d);
    check(d == 8'h00, "R7 busy cleared", d, 0);
    readOffset(ofs);
    check(ofs == 24'h563413, "R6 offset advance", ofs, 24'h563413);

    // R4: streaming reads
    for (int k = 0; k < 16; k++) begin
      hostRead(3'd0, d);
      check(d == romByte(addr + 27'(k)), "R4 stream byte", d, romByte(addr + 27'(k)));
      check(romReq && romAddr == addr + 27'(k + 1), "R4 next request", romAddr, addr + 27'(k + 1));
      waitIdle();
    end
    prev = romByte(addr + 27'd15);

    // R7: consuming read then a second read and a trigger while busy
    hostRead(3'd0, d);
    check(d == romByte(addr + 27'd16), "R7 setup read", d, romByte(addr + 27'd16));
    prev = d;
    hostRead(3'd0, d);
    check(d == prev, "R7 read while busy", d, prev);
    check(romAddr == addr + 27'd17, "R7 address stable", romAddr, addr + 27'd17);
    waitIdle();
    readOffset(ofs);
    check(ofs == 24'h563412 + 24'd18, "R7 single advance", ofs, 24'h563412 + 24'd18);
    hostRead(3'd0, d);
    check(d == romByte(addr + 27'd17), "R7 buffer after busy", d, romByte(addr + 27'd17));
    hostWrite(3'd4, 8'h00);
    check(romAddr == addr + 27'd18, "R7 trigger while busy", romAddr, addr + 27'd18);
    waitIdle();
    readOffset(ofs);
    check(ofs == 24'h563412 + 24'd19, "R7 trigger ignored", ofs, 24'h563412 + 24'd19);

    // R5: bank sweep with the second trigger, aux registers scrambled
    for (int b = 0; b < 8; b++) begin
      hostWrite(3'd6, 8'(7 - b)); hostWrite(3'd7, 8'(b * 3));
      hostWrite(3'd5, 8'(b));
      hostWrite(3'd1, 8'(b * 17)); hostWrite(3'd2, 8'h80); hostWrite(3'd3, 8'(b));
      waitIdle();
      hostWrite(3'd4, 8'h01);
      addr = {3'(b), 8'(b), 8'h80, 8'(b * 17)} + 27'd1;
      check(romAddr == addr, "R5 bank sweep address", romAddr, addr);
      waitIdle();
      hostRead(3'd0, d);
      check(d == romByte(addr), "R3 trigger fill", d, romByte(addr));
      waitIdle();
    end

    // R6: offset wrap
    hostWrite(3'd5, 8'h02);
    hostWrite(3'd1, 8'hFF); hostWrite(3'd2, 8'hFF); hostWrite(3'd3, 8'hFF);
    check(romAddr == {3'd2, 24'hFFFFFF}, "R6 wrap request", romAddr, {3'd2, 24'hFFFFFF});
    waitIdle();
    readOffset(ofs);
    check(ofs == 24'h0, "R6 offset wrapped", ofs, 0);
    hostRead(3'd0, d);
    check(d == romByte({3'd2, 24'hFFFFFF}), "R6 wrap byte", d, romByte({3'd2, 24'hFFFFFF}));
    check(romAddr == {3'd2, 24'h0}, "R6 fetch after wrap", romAddr, {3'd2, 24'h0});
    waitIdle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      runCount++; failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", runCount, failCount);
      $finish;
    end
  end
endmodule